// File: doc/BRIEF.md
# Reorder Buffer with Operand Bypass

This block is a circular queue of in-flight instructions. It lets results come back from the functional units in any order, and it still hands register updates to the architectural register file one at a time, in program order. The dispatch stage claims a slot at the tail for each instruction. It gives the slot the destination register number and the instruction PC, and it receives back a pointer that serves as the instruction's tag. A functional unit finishes by writing its result into the slot named by that tag, together with a flag that says whether the instruction faulted.

The oldest slot retires once its result is present. A normal result appears on the commit port so that the register file can write it. A faulting result is not written. Instead the whole queue is emptied in one cycle, and the PC of the faulting instruction is offered so that fetch can be steered to a handler.

A combinational lookup port serves the rename and dispatch logic. The caller gives a source register and a position in the queue. The port searches only the slots older than that position and picks the youngest writer of that register. It then reports one of three outcomes: the producer's value, the producer's tag if the result has not come back yet, or a miss, in which case the caller reads the register file.

Top module: `rob_top`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `alloc_tag`=0, `commit_valid`=0, `flush_valid`=0 and `lk_hit`=0.
- R2: An accepted allocation (`alloc_valid`&`alloc_ready` at a clock edge) takes the tail slot. `alloc_tag` shows the tail pointer before that edge: the slot index is in bits [2:0], and bit 3 is a wrap bit that toggles each time the pointer passes slot 7.
- R3: While 8 slots are occupied, `alloc_ready` is 0 and `alloc_valid` has no effect.
- R4: A result written with `wb_tag` (the slot index) may arrive for any occupied slot in any order. A slot that is not the oldest never produces commit output.
- R5: When the oldest slot holds a result without a fault, `commit_valid`=1 in that cycle with its `commit_dest` and `commit_data`, and the next oldest slot becomes the oldest after the edge.
- R6: While the oldest slot has no result, or the queue is empty, `commit_valid`=0 and `flush_valid`=0.
- R7: When the oldest slot holds a faulting result, `flush_valid`=1 and `flush_pc` gives its PC. `commit_valid` stays 0 for it, `alloc_ready` is 0 in that cycle, and after the edge the queue is empty (`alloc_tag` equals that slot's pointer).
- R8: The lookup considers only occupied slots older than the position `lk_before` (a pointer in the `alloc_tag` format). Among those, it selects the youngest whose destination equals `lk_reg`. If none matches, `lk_hit`=0.
- R9: On a hit, `lk_ready`=1 with `lk_value` equal to the producer's result if that result has arrived. Otherwise `lk_ready`=0 and `lk_value` is the producer's slot index, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_dest | input | REG_AW | Destination register of the new instruction |
| alloc_pc | input | PC_W | PC of the new instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | IDX_W+1 | Tail pointer given to the new instruction |
| wb_valid | input | 1 | A functional unit returns a result |
| wb_tag | input | IDX_W | Slot index of the result |
| wb_data | input | DATA_W | Result value |
| wb_exc | input | 1 | The instruction faulted |
| commit_valid | output | 1 | Oldest slot retires to the register file |
| commit_dest | output | REG_AW | Register written on commit |
| commit_data | output | DATA_W | Value written on commit |
| flush_valid | output | 1 | Oldest slot faulted; queue is discarded |
| flush_pc | output | PC_W | PC of the faulting instruction |
| lk_reg | input | REG_AW | Source register to resolve |
| lk_before | input | IDX_W+1 | Pointer of the consumer; only older slots are searched |
| lk_hit | output | 1 | An older in-flight writer exists |
| lk_ready | output | 1 | The writer's result is present |
| lk_value | output | DATA_W | Result value, or writer's slot index when not ready |

## Verification
The bench builds the block with its defaults: 8 slots, 5-bit register numbers and 32-bit data and PC. The small depth means that random dispatch at a moderate rate fills the queue again and again and wraps both pointers many times, so the full condition and the wrap bit in `alloc_tag` are exercised often. Source registers for allocation and lookup are drawn from only four values, so several in-flight writers of one register are common. This tests the choice of the youngest older writer and the consumer-position cutoff. Faults are injected on roughly one result in sixteen, which produces flushes with both full and nearly empty queues.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HD_EMPTY  = 2'd0,
    HD_WAIT   = 2'd1,
    HD_RETIRE = 2'd2,
    HD_FAULT  = 2'd3
  } head_state_e;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic             head_done,
  input  logic             head_exc,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic             alloc_ready,
  output logic             alloc_fire,
  output logic             commit_fire,
  output logic             flush_fire,
  output logic             full
);
  import rob_pkg::*;

  logic [PTR_W-1:0] head_q, head_n, tail_q, tail_n, occ;
  head_state_e      hstate;
  logic             empty;

  assign occ   = tail_q - head_q;
  assign empty = (occ == '0);
  assign full  = (occ == PTR_W'(NUM_ENT));

  always_comb begin
    if (empty)          hstate = HD_EMPTY;
    else if (!head_done) hstate = HD_WAIT;
    else if (head_exc)  hstate = HD_FAULT;
    else                hstate = HD_RETIRE;
  end

  assign commit_fire = (hstate == HD_RETIRE);
  assign flush_fire  = (hstate == HD_FAULT);
  assign alloc_ready = !full && !flush_fire;
  assign alloc_fire  = alloc_valid && alloc_ready;

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    if (commit_fire) head_n = head_q + PTR_W'(1);
    if (flush_fire)      tail_n = head_q;
    else if (alloc_fire) tail_n = tail_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
    end
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int NUM_ENT = 8,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 32,
  parameter int PC_W    = 32,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            alloc_fire,
  input  logic [IDX_W-1:0]                alloc_idx,
  input  logic [REG_AW-1:0]               alloc_dest,
  input  logic [PC_W-1:0]                 alloc_pc,
  input  logic                            wb_valid,
  input  logic [IDX_W-1:0]                wb_idx,
  input  logic [DATA_W-1:0]               wb_data,
  input  logic                            wb_exc,
  output logic [NUM_ENT-1:0][REG_AW-1:0]  dest_q,
  output logic [NUM_ENT-1:0][PC_W-1:0]    pc_q,
  output logic [NUM_ENT-1:0][DATA_W-1:0]  data_q,
  output logic [NUM_ENT-1:0]              done_q,
  output logic [NUM_ENT-1:0]              exc_q
);
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    logic sel_alloc, sel_wb;
    assign sel_alloc = alloc_fire && (alloc_idx == IDX_W'(g));
    assign sel_wb    = wb_valid && (wb_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q[g] <= 1'b0;
        exc_q[g]  <= 1'b0;
      end else if (sel_alloc) begin
        done_q[g] <= 1'b0;
        exc_q[g]  <= 1'b0;
      end else if (sel_wb) begin
        done_q[g] <= 1'b1;
        exc_q[g]  <= wb_exc;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_alloc) begin
        dest_q[g] <= alloc_dest;
        pc_q[g]   <= alloc_pc;
      end
      if (sel_wb) data_q[g] <= wb_data;
    end
  end
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
  parameter int NUM_ENT = 8,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 32,
  localparam int IDX_W = $clog2(NUM_ENT),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [PTR_W-1:0]               head_ptr,
  input  logic [PTR_W-1:0]               tail_ptr,
  input  logic [PTR_W-1:0]               lk_before,
  input  logic [REG_AW-1:0]              lk_reg,
  input  logic [NUM_ENT-1:0][REG_AW-1:0] dest_q,
  input  logic [NUM_ENT-1:0][DATA_W-1:0] data_q,
  input  logic [NUM_ENT-1:0]             done_q,
  output logic                           lk_hit,
  output logic                           lk_ready,
  output logic [DATA_W-1:0]              lk_value
);
  logic [PTR_W-1:0] occ, span, lim;
  logic [IDX_W-1:0] sel, idx;

  assign occ  = tail_ptr - head_ptr;
  assign span = lk_before - head_ptr;
  assign lim  = (span < occ) ? span : occ;

  always_comb begin
    lk_hit = 1'b0;
    sel    = '0;
    idx    = '0;
    for (int k = 0; k < NUM_ENT; k++) begin
      idx = head_ptr[IDX_W-1:0] + IDX_W'(k);
      if ((PTR_W'(k) < lim) && (dest_q[idx] == lk_reg)) begin
        lk_hit = 1'b1;
        sel    = idx;
      end
    end
  end

  assign lk_ready = lk_hit && done_q[sel];
  assign lk_value = !lk_hit   ? '0 :
                    lk_ready  ? data_q[sel] : DATA_W'(sel);
endmodule

// File: rtl/rob_top.sv
module rob_top #(
  parameter int NUM_ENT = 8,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 32,
  parameter int PC_W    = 32,
  localparam int IDX_W = $clog2(NUM_ENT),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_AW-1:0] alloc_dest,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [PTR_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_exc,
  output logic              commit_valid,
  output logic [REG_AW-1:0] commit_dest,
  output logic [DATA_W-1:0] commit_data,
  output logic              flush_valid,
  output logic [PC_W-1:0]   flush_pc,
  input  logic [REG_AW-1:0] lk_reg,
  input  logic [PTR_W-1:0]  lk_before,
  output logic              lk_hit,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_value
);
  logic [PTR_W-1:0]               head_ptr, tail_ptr;
  logic                           alloc_fire, commit_fire, flush_fire, full;
  logic [NUM_ENT-1:0][REG_AW-1:0] dest_q;
  logic [NUM_ENT-1:0][PC_W-1:0]   pc_q;
  logic [NUM_ENT-1:0][DATA_W-1:0] data_q;
  logic [NUM_ENT-1:0]             done_q, exc_q;
  logic [IDX_W-1:0]               head_idx;

  assign head_idx = head_ptr[IDX_W-1:0];

  rob_ctrl #(.NUM_ENT(NUM_ENT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
    .head_done(done_q[head_idx]), .head_exc(exc_q[head_idx]),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .alloc_ready(alloc_ready),
    .alloc_fire(alloc_fire), .commit_fire(commit_fire),
    .flush_fire(flush_fire), .full(full)
  );

  rob_store #(.NUM_ENT(NUM_ENT), .REG_AW(REG_AW), .DATA_W(DATA_W), .PC_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire),
    .alloc_idx(tail_ptr[IDX_W-1:0]), .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
    .wb_valid(wb_valid), .wb_idx(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
    .dest_q(dest_q), .pc_q(pc_q), .data_q(data_q), .done_q(done_q), .exc_q(exc_q)
  );

  rob_lookup #(.NUM_ENT(NUM_ENT), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_lookup (
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .lk_before(lk_before), .lk_reg(lk_reg),
    .dest_q(dest_q), .data_q(data_q), .done_q(done_q),
    .lk_hit(lk_hit), .lk_ready(lk_ready), .lk_value(lk_value)
  );

  assign alloc_tag    = tail_ptr;
  assign commit_valid = commit_fire;
  assign commit_dest  = dest_q[head_idx];
  assign commit_data  = data_q[head_idx];
  assign flush_valid  = flush_fire;
  assign flush_pc     = pc_q[head_idx];
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] head_ptr,
  input logic [PTR_W-1:0] tail_ptr,
  input logic             full,
  input logic             alloc_ready,
  input logic             commit_valid,
  input logic             flush_valid,
  input logic             lk_hit,
  input logic             lk_ready
);
  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ready);
  a_r3_full_tail_still: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush_valid) |=> tail_ptr == $past(tail_ptr));
  a_r5_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head_ptr == $past(head_ptr) + PTR_W'(1));
  a_r6_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_valid |=> $stable(head_ptr));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> tail_ptr == head_ptr);
  a_r7_no_dual_retire: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_valid && flush_valid));
  a_r9_ready_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready |-> lk_hit);
endmodule

bind rob_top rob_chk #(.PTR_W(PTR_W)) u_rob_chk (
  .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
  .full(full), .alloc_ready(alloc_ready), .commit_valid(commit_valid),
  .flush_valid(flush_valid), .lk_hit(lk_hit), .lk_ready(lk_ready)
);

// File: tb/tb_rob_top.sv
module tb_rob_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [4:0]  alloc_dest = '0;
  logic [31:0] alloc_pc = '0;
  logic        alloc_ready;
  logic [3:0]  alloc_tag;
  logic        wb_valid = 1'b0;
  logic [2:0]  wb_tag = '0;
  logic [31:0] wb_data = '0;
  logic        wb_exc = 1'b0;
  logic        commit_valid, flush_valid, lk_hit, lk_ready;
  logic [4:0]  commit_dest;
  logic [31:0] commit_data, flush_pc, lk_value;
  logic [4:0]  lk_reg = '0;
  logic [3:0]  lk_before = '0;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  int m_hp = 0, m_cnt = 0;
  logic [4:0]  m_dest [N];
  logic [31:0] m_pc [N], m_data [N];
  bit          m_done [N], m_exc [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_top dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int hidx();
    return m_hp % N;
  endfunction

  // one cycle: drive at negedge, check, advance model for the coming edge
  task automatic step(input bit av, input logic [4:0] ad, input logic [31:0] apc,
                      input bit wv, input int woff, input logic [31:0] wd, input bit we,
                      input logic [4:0] lr, input int loff);
    int widx, aidx, sel;
    bit e_hd, e_com, e_fl, e_rdy, e_hit;
    @(negedge clk);
    widx = (m_hp + woff) % N;
    if (wv && (woff >= m_cnt || m_done[widx])) wv = 0;
    alloc_valid = av; alloc_dest = ad; alloc_pc = apc;
    wb_valid = wv; wb_tag = 3'(widx); wb_data = wd; wb_exc = we;
    if (loff > m_cnt) loff = m_cnt;
    lk_reg = lr; lk_before = 4'((m_hp + loff) % 16);
    #1;
    e_hd  = (m_cnt > 0) && m_done[hidx()];
    e_com = e_hd && !m_exc[hidx()];
    e_fl  = e_hd && m_exc[hidx()];
    e_rdy = (m_cnt < N) && !e_fl;
    chk(alloc_ready == e_rdy, (m_cnt == N) ? "R3 full ready" : (e_fl ? "R7 ready" : "R2 ready"),
        32'(alloc_ready), 32'(e_rdy));
    if (e_rdy) chk(alloc_tag == 4'((m_hp + m_cnt) % 16), "R2 tag", 32'(alloc_tag), 32'((m_hp + m_cnt) % 16));
    chk(commit_valid == e_com, e_hd ? "R5 commit_valid" : "R6 idle", 32'(commit_valid), 32'(e_com));
    chk(flush_valid == e_fl, e_fl ? "R7 flush_valid" : "R4 flush_valid", 32'(flush_valid), 32'(e_fl));
    if (e_com) begin
      chk(commit_dest == m_dest[hidx()], "R5 dest", 32'(commit_dest), 32'(m_dest[hidx()]));
      chk(commit_data == m_data[hidx()], "R5 data", commit_data, m_data[hidx()]);
    end
    if (e_fl) chk(flush_pc == m_pc[hidx()], "R7 pc", flush_pc, m_pc[hidx()]);
    e_hit = 0; sel = 0;
    for (int k = 0; k < loff; k++) begin
      if (m_dest[(m_hp + k) % N] == lr) begin e_hit = 1; sel = (m_hp + k) % N; end
    end
    chk(lk_hit == e_hit, "R8 hit", 32'(lk_hit), 32'(e_hit));
    if (e_hit) begin
      chk(lk_ready == m_done[sel], "R9 ready", 32'(lk_ready), 32'(m_done[sel]));
      if (m_done[sel]) chk(lk_value == m_data[sel], "R9 value", lk_value, m_data[sel]);
      else chk(lk_value == 32'(sel), "R9 tag", lk_value, 32'(sel));
    end
    // model update for the edge
    aidx = (m_hp + m_cnt) % N;
    if (wv) begin m_done[widx] = 1; m_data[widx] = wd; m_exc[widx] = we; end
    if (e_com) begin m_hp = (m_hp + 1) % 16; m_cnt--; end
    if (av && e_rdy) begin
      m_dest[aidx] = ad; m_pc[aidx] = apc; m_done[aidx] = 0; m_exc[aidx] = 0; m_cnt++;
    end
    if (e_fl) m_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < N; i++) begin m_done[i] = 0; m_exc[i] = 0; m_dest[i] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(alloc_ready == 1'b1, "R1 ready", 32'(alloc_ready), 1);
    chk(alloc_tag == 4'd0, "R1 tag", 32'(alloc_tag), 0);
    chk(commit_valid == 1'b0, "R1 commit", 32'(commit_valid), 0);
    chk(flush_valid == 1'b0, "R1 flush", 32'(flush_valid), 0);
    chk(lk_hit == 1'b0, "R1 hit", 32'(lk_hit), 0);
    // fill the queue; several writers of r1 and r2 (R2, R3, R8)
    for (int i = 0; i < N; i++)
      step(1, 5'(1 + (i % 2)), 32'h100 + 32'(i), 0, 0, 0, 0, 5'd1, i);
    // R3: full, further requests ignored, lookup sees all older writers
    step(1, 5'd9, 32'hdead, 0, 0, 0, 0, 5'd1, N);
    step(1, 5'd9, 32'hdead, 0, 0, 0, 0, 5'd9, N);
    // R4: out of order results, younger first
    step(0, 0, 0, 1, 3, 32'hAAA3, 0, 5'd2, N);
    step(0, 0, 0, 1, 2, 32'hAAA2, 0, 5'd1, 3);
    step(0, 0, 0, 1, 0, 32'hAAA0, 0, 5'd1, 3);
    step(0, 0, 0, 1, 1, 32'hAAA1, 0, 5'd2, 2);
    step(0, 0, 0, 0, 0, 0, 0, 5'd1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 5'd2, 4);
    step(0, 0, 0, 0, 0, 0, 0, 5'd1, 4);
    // R7: fault on head with younger entries present
    step(0, 0, 0, 1, 0, 32'hBAD, 1, 5'd1, 4);
    step(1, 5'd3, 32'h500, 1, 2, 32'h1, 0, 5'd1, 4);
    step(1, 5'd3, 32'h501, 0, 0, 0, 0, 5'd3, 0);
    step(0, 0, 0, 0, 0, 0, 0, 5'd3, 1);
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      step($urandom_range(0, 99) < 55, 5'($urandom_range(0, 3)), $urandom,
           $urandom_range(0, 99) < 45, $urandom_range(0, N - 1), $urandom,
           $urandom_range(0, 15) == 0, 5'($urandom_range(0, 3)), $urandom_range(0, N));
    end
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule